// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block maps a flat 32-bit virtual address space onto a smaller physical address space through four programmable windows. Three windows map memory and one maps registers. A host loads a start address for every window and a size for the first three over a small configuration write port. The fourth window has a fixed size set by a parameter. Each request carries a valid bit and a virtual address. One cycle later the block returns a hit flag and the translated physical address.

The windows are packed back to back in physical space, in window order. Window 0 begins at physical address zero. The physical base of every later window is the sum of the sizes of the windows before it, so no window has its own physical base register. The fourth window stays disabled until its start register has been written. As a result, no window can match anything after reset.

Top module: `addr_window_xlate`

## Requirements
- R1: After reset every start and size register is zero and window 3 is disabled, so any request misses.
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high, and low in every other cycle.
- R3: An address that hits window 0 translates to (address − start0).
- R4: An address that hits window 1 translates to size0 + (address − start1).
- R5: An address that hits window 2 translates to size0 + size1 + (address − start2).
- R6: Window 3 has size `W3_SIZE` (default 4096) and base size0 + size1 + size2. It matches nothing until its start register has been written.
- R7: A window matches when start ≤ address < start + size. The end address is exclusive, and an address below start misses.
- R8: When several windows match, the lowest-numbered window decides the translation.
- R9: A valid response that misses has `rsp_hit` = 0 and `rsp_addr` = 0.
- R10: A configuration write in the same cycle as a request does not affect that request. It does affect the next request.
- R11: `cfg_idx` selects the register: 0 start0, 1 size0, 2 start1, 3 size1, 4 start2, 5 size2, 6 start3. Index 7 is ignored and changes no translation.
- R12: While `rsp_valid` is low, `rsp_hit` and `rsp_addr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 3 | Configuration register select |
| cfg_data | input | AW | Configuration write data |
| req_valid | input | 1 | Request valid |
| req_addr | input | AW | Virtual address |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | A window matched |
| rsp_addr | output | AW | Physical address, zero on a miss |

## Verification
Every translation result is due on the clock edge that follows the edge where its request was sampled. Configuration writes take effect at that same edge, so their effect first shows on a request presented one cycle later. The bench drives inputs on falling edges and queues the expected hit flag and address when it presents a request. On the next falling edge, its monitor compares the registered outputs against the head of that queue. It also checks that `rsp_valid` mirrors the bench's own record of the previous cycle's `req_valid`. A test that writes configuration and presents a request in the same cycle expects the old mapping for that request.

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int AW      = 32,
  parameter int W3_SIZE = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_idx,
  input  logic [AW-1:0] cfg_data,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [AW-1:0] rsp_addr
);
  localparam int NWIN = 4;

  logic [AW-1:0] start_q [NWIN];
  logic [AW-1:0] size_q  [NWIN-1];
  logic          w3_armed;

  logic [AW-1:0] size [NWIN];
  logic [AW-1:0] base [NWIN];
  logic [AW-1:0] off  [NWIN];
  logic [NWIN-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) start_q[i] <= '0;
      for (int i = 0; i < NWIN-1; i++) size_q[i] <= '0;
      w3_armed <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_idx)
        3'd0: start_q[0] <= cfg_data;
        3'd1: size_q[0]  <= cfg_data;
        3'd2: start_q[1] <= cfg_data;
        3'd3: size_q[1]  <= cfg_data;
        3'd4: start_q[2] <= cfg_data;
        3'd5: size_q[2]  <= cfg_data;
        3'd6: begin start_q[3] <= cfg_data; w3_armed <= 1'b1; end
        default: ;
      endcase
    end
  end

  assign size[3] = w3_armed ? AW'(W3_SIZE) : '0;
  assign base[0] = '0;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    if (g < NWIN-1) begin : g_sz
      assign size[g] = size_q[g];
    end
    if (g > 0) begin : g_base
      assign base[g] = base[g-1] + size[g-1];
    end
    assign off[g] = req_addr - start_q[g];
    assign hit[g] = (req_addr >= start_q[g]) && (off[g] < size[g]);
  end

  logic          nx_hit;
  logic [AW-1:0] nx_addr;
  always_comb begin
    nx_hit  = 1'b0;
    nx_addr = '0;
    for (int i = NWIN-1; i >= 0; i--) begin
      if (hit[i]) begin
        nx_hit  = 1'b1;
        nx_addr = base[i] + off[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && nx_hit;
      rsp_addr  <= req_valid ? nx_addr : '0;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_miss_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && rsp_addr == '0));
  assert_w3_dormant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !w3_armed && hit[2:0] == '0) |=> !rsp_hit);
  assert_win0_in_bounds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit[0]) |=> (rsp_hit && rsp_addr < $past(size_q[0])));
endmodule

// File: tb/sim_addr_window_xlate.sv
module sim_addr_window_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          rsp_valid, rsp_hit;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  logic [AW:0] exp_q [$];
  string       tag_q [$];
  logic        drove_q = 1'b0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_xlate #(.AW(AW), .W3_SIZE(4096)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr));

  always @(posedge clk) drove_q <= rst_n && req_valid;

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rsp_valid !== drove_q) begin
        errors++;
        $display("FAIL R2 rsp_valid actual=%0b expected=%0b", rsp_valid, drove_q);
      end
      if (rsp_valid && exp_q.size() > 0) begin
        logic [AW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({rsp_hit, rsp_addr} !== e) begin
          errors++;
          $display("FAIL %s hit/addr actual=%0b/%h expected=%0b/%h", t, rsp_hit, rsp_addr, e[AW], e[AW-1:0]);
        end
      end else if (!rsp_valid) begin
        checks++;
        if (rsp_hit !== 1'b0 || rsp_addr !== '0) begin
          errors++;
          $display("FAIL R12 idle outputs actual=%0b/%h expected=0/0", rsp_hit, rsp_addr);
        end
      end
    end
  end

  task automatic cfg(input logic [2:0] idx, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [AW-1:0] a, input logic h, input logic [AW-1:0] pa, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    exp_q.push_back({h, pa});
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_addr !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b%0b/%h expected=00/0", rsp_valid, rsp_hit, rsp_addr);
    end
    rst_n = 1'b1;
    access(32'h0000_0000, 1'b0, '0, "R1 zero addr after reset");
    access(32'h1000_0000, 1'b0, '0, "R1 any addr after reset");

    cfg(3'd0, 32'h1000_0000); cfg(3'd1, 32'h0000_1000);
    cfg(3'd2, 32'h2000_0000); cfg(3'd3, 32'h0000_0800);
    cfg(3'd4, 32'h3000_0000); cfg(3'd5, 32'h0000_0400);

    access(32'h1000_0010, 1'b1, 32'h0000_0010, "R3 win0");
    access(32'h1000_0FFF, 1'b1, 32'h0000_0FFF, "R7 win0 last byte");
    access(32'h1000_1000, 1'b0, '0, "R7 win0 end exclusive");
    access(32'h0FFF_FFFF, 1'b0, '0, "R7 below start");
    access(32'h2000_0004, 1'b1, 32'h0000_1004, "R4 win1");
    access(32'h3000_03FC, 1'b1, 32'h0000_1BFC, "R5 win2");
    access(32'h4000_0000, 1'b0, '0, "R6 win3 dormant");
    access(32'h5555_0000, 1'b0, '0, "R9 miss");

    cfg(3'd6, 32'h4000_0000);
    access(32'h4000_0020, 1'b1, 32'h0000_1C20, "R6 win3");
    access(32'h4000_0FFF, 1'b1, 32'h0000_2BFF, "R6 win3 last");
    access(32'h4000_1000, 1'b0, '0, "R6 win3 end");

    cfg(3'd7, 32'h1000_0000);
    access(32'h3000_0000, 1'b1, 32'h0000_1800, "R11 idx7 ignored win2");
    access(32'h1000_0000, 1'b1, 32'h0000_0000, "R11 idx7 ignored win0");

    cfg(3'd2, 32'h1000_0C00);
    access(32'h1000_0D00, 1'b1, 32'h0000_0D00, "R8 overlap lowest wins");
    access(32'h1000_1000, 1'b1, 32'h0000_1400, "R8 win1 beyond win0");

    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd1; cfg_data = 32'h0000_2000;
    req_valid = 1'b1; req_addr = 32'h1000_1800;
    exp_q.push_back({1'b0, 32'h0}); tag_q.push_back("R10 same-cycle write unseen");
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    access(32'h1000_1800, 1'b1, 32'h0000_1800, "R10 write seen next");
    access(32'h3000_0010, 1'b1, 32'h0000_2810, "R5 base after resize");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 pending responses actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule